// File: doc/BRIEF.md
# Battery-Tracking Peak Limiter

This block is a single-channel digital peak limiter for signed 24-bit audio samples. Each accepted sample is scaled by a gain held as an 8-bit reduction count `a`, giving `out = (in * (256 - a)) >>> 8`. When the sample magnitude is above a threshold, the count rises at a selectable attack rate. When the magnitude is at or below the threshold, the count falls at a selectable release rate. The threshold comes from a 5-bit setting. It can also be lowered in proportion to how far an 8-bit supply-voltage code sits below an inflection code, so the output level drops as the battery discharges.

A 2-bit mode field picks one of four behaviours:
- off (plain pass-through);
- always limiting;
- mute while the battery is low, fixed-threshold limiting otherwise;
- limiting only while the battery is low.

The low-battery condition has a hysteresis margin, so it does not chatter at the inflection point. An engaged flag tells the system that gain is being reduced or that the output is muted.

The controller is a five-state machine:
- `ST_BYPASS`: mode off, count cleared.
- `ST_IDLE`: active, no reduction.
- `ST_ATTACK`: magnitude above threshold.
- `ST_RELEASE`: count above zero and magnitude not above threshold.
- `ST_MUTE`: muted on low battery.

Transitions happen only on accepted samples:
- `IDLE/RELEASE -> ATTACK` on an over-threshold sample.
- `ATTACK -> RELEASE` when the magnitude falls back while the count is nonzero.
- `ATTACK/RELEASE -> IDLE` when the count is or reaches zero and the magnitude is not above threshold.
- `any -> MUTE` on the low-battery mute condition.
- `any -> BYPASS` when the mode is off.
- `MUTE/BYPASS -> IDLE` or `ATTACK` when the mode becomes active again.

Top module: `batt_track_limiter`

## Requirements
- R1: In reset, and on the first clock after it, `out_valid`, `sample_out` and `engaged` are 0, the reduction count is 0 and the low-battery flag is clear.
- R2: With mode 2'b00, `sample_out` equals `sample_in` one clock after an accepted sample. The count is cleared and `engaged` is 0.
- R3: `out_valid` equals `in_valid` delayed by one clock. In the active modes, when not muted, `sample_out = (sample_in * (256 - a)) >>> 8`, where `a` is the count before that sample.
- R4: When an accepted sample's magnitude is strictly above the threshold, the count rises by 1 every P accepted samples. P is 1, 2, 4 or 8 for `attack_sel` 00, 01, 10 or 11. The count saturates at 192. A direction change restarts the sample count.
- R5: When an accepted sample's magnitude is not above the threshold and the count is nonzero, the count falls by 1 every Q accepted samples. Q is 16, 8, 6 or 4 for `release_sel` 00, 01, 10 or 11.
- R6: The set threshold is `(4 + thresh_sel) * 2^17`. A magnitude equal to the threshold does not attack. The magnitude of -2^23 is 2^23.
- R7: With `track_en` set, in modes 01 and 11, the threshold is lowered by `(slope_sel + 1) * (infl_code - batt_code) * 2^15` when `batt_code < infl_code`. It never goes below 2^17.
- R8: The low-battery flag sets on a clock where `batt_code < infl_code`. It clears only when `batt_code >= infl_code + 4`, summed in 9 bits. It holds otherwise, and the new value acts from the next clock.
- R9: In mode 10, while the flag is set, `sample_out` is 0 and the count is cleared. While the flag is clear, the set threshold is used even with `track_en` high.
- R10: In mode 11, while the flag is clear, no sample attacks and a nonzero count releases. While the flag is set, the block limits like mode 01.
- R11: `engaged` is 1 exactly when the count is nonzero or the block is in the mute state.
- R12: Clocks without `in_valid` change neither the count, the state nor `sample_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| sample_in | input | 24 | Signed input sample |
| batt_code | input | 8 | Supply voltage code, 0 to 255 linear |
| infl_code | input | 8 | Inflection supply code |
| lim_mode | input | 2 | 00 off, 01 always, 10 mute-on-low, 11 low-only |
| track_en | input | 1 | Threshold follows supply code |
| slope_sel | input | 2 | Tracking slope minus one |
| thresh_sel | input | 5 | Set threshold code |
| attack_sel | input | 2 | Attack rate select |
| release_sel | input | 2 | Release rate select |
| out_valid | output | 1 | Output strobe |
| sample_out | output | 24 | Limited signed sample |
| engaged | output | 1 | Gain reduced or muted |

## Verification
Several input patterns each separate a different behaviour:
- Steady over-threshold runs of positive, negative and most-negative samples tell attack pacing apart from saturation.
- Under-threshold runs separate each release pacing.
- A sample exactly at the threshold separates strict from non-strict comparison.
- A sample placed between the fixed and the tracked thresholds shows whether tracking, the slope and the floor are applied, and whether mode 10 ignores tracking.
- Supply codes below, inside and above the hysteresis band show when the low flag sets, holds and clears.
- Idle gaps between samples show that nothing advances without a strobe.

// File: rtl/lim_pkg.sv
package lim_pkg;

    typedef enum logic [2:0] {
        ST_BYPASS  = 3'd0,
        ST_IDLE    = 3'd1,
        ST_ATTACK  = 3'd2,
        ST_RELEASE = 3'd3,
        ST_MUTE    = 3'd4
    } lim_state_t;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'b00,
        MODE_ON       = 2'b01,
        MODE_MUTE_LOW = 2'b10,
        MODE_LOW_ONLY = 2'b11
    } lim_mode_t;

    // samples per attack step, before rate scaling
    function automatic int att_period(input logic [1:0] sel);
        return 1 << sel;
    endfunction

    // samples per release step, before rate scaling
    function automatic int rel_period(input logic [1:0] sel);
        case (sel)
            2'b00:   return 16;
            2'b01:   return 8;
            2'b10:   return 6;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/lim_batt_monitor.sv
module lim_batt_monitor #(
    parameter int BATT_W = 8,
    parameter int MAG_W  = 24,
    parameter int THR_W  = 5,
    parameter int HYST   = 4,
    parameter int THR_OFS = 4,
    parameter int THR_SH = 17,
    parameter int BAT_SH = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BATT_W-1:0] batt_code,
    input  logic [BATT_W-1:0] infl_code,
    input  logic [1:0]        slope_sel,
    input  logic [THR_W-1:0]  thresh_sel,
    output logic              low_q,
    output logic [MAG_W-1:0]  thr_set,
    output logic [MAG_W-1:0]  thr_trk
);
    localparam int WIDE_W = MAG_W + BATT_W;

    logic              below;
    logic              clear_ok;
    logic [BATT_W-1:0] diff;
    logic [WIDE_W-1:0] drop;
    logic [WIDE_W-1:0] floor_w;

    assign below    = batt_code < infl_code;
    assign clear_ok = {1'b0, batt_code} >= ({1'b0, infl_code} + (BATT_W+1)'(HYST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_q <= 1'b0;
        else if (below)    low_q <= 1'b1;
        else if (clear_ok) low_q <= 1'b0;
    end

    assign thr_set = (MAG_W'(thresh_sel) + MAG_W'(THR_OFS)) << THR_SH;
    assign diff    = below ? (infl_code - batt_code) : '0;
    assign drop    = (WIDE_W'(diff) * WIDE_W'(slope_sel) + WIDE_W'(diff)) << BAT_SH;
    assign floor_w = WIDE_W'(1) << THR_SH;

    always_comb begin
        if (WIDE_W'(thr_set) > drop + floor_w)
            thr_trk = thr_set - drop[MAG_W-1:0];
        else
            thr_trk = floor_w[MAG_W-1:0];
    end

    // R8
    low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_code < infl_code) |=> low_q);

    // R8
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q && ({1'b0, batt_code} < {1'b0, infl_code} + (BATT_W+1)'(HYST))) |=> low_q);

endmodule

// File: rtl/lim_gain_ctrl.sv
module lim_gain_ctrl
    import lim_pkg::*;
#(
    parameter int MAG_W     = 24,
    parameter int ATT_W     = 8,
    parameter int MAX_ATTEN = 192,
    parameter int RATE_MUL  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MAG_W-1:0] peak,
    input  logic [1:0]       lim_mode,
    input  logic             track_en,
    input  logic             low_q,
    input  logic [MAG_W-1:0] thr_set,
    input  logic [MAG_W-1:0] thr_trk,
    input  logic [1:0]       attack_sel,
    input  logic [1:0]       release_sel,
    output logic [ATT_W-1:0] atten_q,
    output logic             mute_now,
    output logic             bypass,
    output logic             engaged
);
    localparam int CNT_W = $clog2(16 * RATE_MUL) + 1;

    lim_mode_t        mode_e;
    lim_state_t       state_q, state_d;
    logic [ATT_W-1:0] atten_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, base;
    logic [CNT_W-1:0] att_per, rel_per;
    logic             active, use_trk, over;
    logic [MAG_W-1:0] thr_use;

    assign mode_e  = lim_mode_t'(lim_mode);
    assign att_per = CNT_W'(att_period(attack_sel) * RATE_MUL);
    assign rel_per = CNT_W'(rel_period(release_sel) * RATE_MUL);

    assign mute_now = (mode_e == MODE_MUTE_LOW) && low_q;
    assign active   = (mode_e == MODE_ON) ||
                      ((mode_e == MODE_MUTE_LOW) && !low_q) ||
                      ((mode_e == MODE_LOW_ONLY) && low_q);
    assign use_trk  = track_en && ((mode_e == MODE_ON) || (mode_e == MODE_LOW_ONLY));
    assign thr_use  = use_trk ? thr_trk : thr_set;
    assign over     = active && (peak > thr_use);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            atten_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            atten_q <= atten_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        atten_d = atten_q;
        cnt_d   = cnt_q;
        base    = '0;
        if (in_valid) begin
            unique case (mode_e)
                MODE_OFF: begin
                    state_d = ST_BYPASS;
                    atten_d = '0;
                    cnt_d   = '0;
                end
                MODE_ON, MODE_MUTE_LOW, MODE_LOW_ONLY: begin
                    if (mute_now) begin
                        state_d = ST_MUTE;
                        atten_d = '0;
                        cnt_d   = '0;
                    end else if (over) begin
                        base    = (state_q == ST_ATTACK) ? cnt_q : '0;
                        state_d = ST_ATTACK;
                        if (base + CNT_W'(1) >= att_per) begin
                            cnt_d = '0;
                            if (atten_q < ATT_W'(MAX_ATTEN))
                                atten_d = atten_q + ATT_W'(1);
                        end else begin
                            cnt_d = base + CNT_W'(1);
                        end
                    end else if (atten_q == '0) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        base = (state_q == ST_RELEASE) ? cnt_q : '0;
                        if (base + CNT_W'(1) >= rel_per) begin
                            cnt_d   = '0;
                            atten_d = atten_q - ATT_W'(1);
                            state_d = (atten_q == ATT_W'(1)) ? ST_IDLE : ST_RELEASE;
                        end else begin
                            cnt_d   = base + CNT_W'(1);
                            state_d = ST_RELEASE;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        bypass  = (mode_e == MODE_OFF);
        engaged = (atten_q != '0) || (state_q == ST_MUTE);
    end

    // R4
    atten_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        atten_q <= ATT_W'(MAX_ATTEN));

    // R5
    atten_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_q == $past(atten_q)) || (atten_q == $past(atten_q) + ATT_W'(1)) ||
        (atten_q + ATT_W'(1) == $past(atten_q)) || (atten_q == '0));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(atten_q) && $stable(state_q)));

    // R2
    bypass_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lim_mode == 2'b00)) |=> ((atten_q == '0) && !engaged));

    // R9
    mute_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_now) |=> ((state_q == ST_MUTE) && (atten_q == '0) && engaged));

    // R10
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (lim_mode == 2'b11) && !low_q) |=> (atten_q <= $past(atten_q)));

endmodule

// File: rtl/lim_gain_apply.sv
module lim_gain_apply #(
    parameter int MAG_W = 24,
    parameter int ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [MAG_W-1:0] sample_in,
    input  logic [ATT_W-1:0] atten,
    input  logic             bypass,
    input  logic             mute_now,
    output logic             out_valid,
    output logic [MAG_W-1:0] sample_out
);
    localparam int PROD_W = MAG_W + ATT_W + 1;
    localparam logic [ATT_W:0] UNITY = (ATT_W+1)'(1) << ATT_W;

    logic [ATT_W:0]   gain;
    logic [MAG_W-1:0] scaled;

    assign gain   = UNITY - {1'b0, atten};
    assign scaled = MAG_W'(($signed({{(ATT_W+1){sample_in[MAG_W-1]}}, sample_in}) *
                             $signed({{MAG_W{1'b0}}, gain})) >>> ATT_W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            sample_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (bypass)        sample_out <= sample_in;
                else if (mute_now) sample_out <= '0;
                else               sample_out <= scaled;
            end
        end
    end

    // R3
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R3
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sample_out)));

    // R9
    mute_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_now && !bypass) |=> (sample_out == '0));

endmodule

// File: rtl/batt_track_limiter.sv
module batt_track_limiter #(
    parameter int MAG_W     = 24,
    parameter int BATT_W    = 8,
    parameter int THR_W     = 5,
    parameter int ATT_W     = 8,
    parameter int MAX_ATTEN = 192,
    parameter int HYST      = 4,
    parameter int RATE_MUL  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAG_W-1:0]  sample_in,
    input  logic [BATT_W-1:0] batt_code,
    input  logic [BATT_W-1:0] infl_code,
    input  logic [1:0]        lim_mode,
    input  logic              track_en,
    input  logic [1:0]        slope_sel,
    input  logic [THR_W-1:0]  thresh_sel,
    input  logic [1:0]        attack_sel,
    input  logic [1:0]        release_sel,
    output logic              out_valid,
    output logic [MAG_W-1:0]  sample_out,
    output logic              engaged
);
    logic             low_q;
    logic [MAG_W-1:0] thr_set, thr_trk, peak;
    logic [ATT_W-1:0] atten;
    logic             mute_now, bypass;

    // magnitude; the most negative value maps to 2^(MAG_W-1) unsigned
    assign peak = sample_in[MAG_W-1] ? (~sample_in + MAG_W'(1)) : sample_in;

    lim_batt_monitor #(
        .BATT_W(BATT_W), .MAG_W(MAG_W), .THR_W(THR_W), .HYST(HYST),
        .THR_OFS(4), .THR_SH(MAG_W-7), .BAT_SH(MAG_W-9)
    ) u_mon (
        .clk(clk), .rst_n(rst_n),
        .batt_code(batt_code), .infl_code(infl_code),
        .slope_sel(slope_sel), .thresh_sel(thresh_sel),
        .low_q(low_q), .thr_set(thr_set), .thr_trk(thr_trk)
    );

    lim_gain_ctrl #(
        .MAG_W(MAG_W), .ATT_W(ATT_W), .MAX_ATTEN(MAX_ATTEN), .RATE_MUL(RATE_MUL)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .peak(peak),
        .lim_mode(lim_mode), .track_en(track_en), .low_q(low_q),
        .thr_set(thr_set), .thr_trk(thr_trk),
        .attack_sel(attack_sel), .release_sel(release_sel),
        .atten_q(atten), .mute_now(mute_now), .bypass(bypass), .engaged(engaged)
    );

    lim_gain_apply #(.MAG_W(MAG_W), .ATT_W(ATT_W)) u_apply (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample_in(sample_in),
        .atten(atten), .bypass(bypass), .mute_now(mute_now),
        .out_valid(out_valid), .sample_out(sample_out)
    );

endmodule

// File: tb/tb_batt_track_limiter.sv
module tb_batt_track_limiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] sample_in = '0;
    logic [7:0]  batt_code = 8'd200;
    logic [7:0]  infl_code = 8'd120;
    logic [1:0]  lim_mode = 2'b00;
    logic        track_en = 1'b0;
    logic [1:0]  slope_sel = 2'b00;
    logic [4:0]  thresh_sel = '0;
    logic [1:0]  attack_sel = 2'b00;
    logic [1:0]  release_sel = 2'b00;
    logic        out_valid;
    logic [23:0] sample_out;
    logic        engaged;

    always #5 clk = ~clk;

    batt_track_limiter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample_in(sample_in),
        .batt_code(batt_code), .infl_code(infl_code), .lim_mode(lim_mode),
        .track_en(track_en), .slope_sel(slope_sel), .thresh_sel(thresh_sel),
        .attack_sel(attack_sel), .release_sel(release_sel),
        .out_valid(out_valid), .sample_out(sample_out), .engaged(engaged)
    );

    int checks = 0;
    int errors = 0;

    // reference state from the requirements: count, state (0 byp,1 idle,2 att,3 rel,4 mute), pacing, low flag
    int m_a = 0, m_st = 1, m_cnt = 0;
    bit m_low = 1'b0;

    typedef struct packed {
        logic [1:0]  mode;
        logic        trk;
        logic [1:0]  slope;
        logic [4:0]  thr;
        logic [1:0]  att;
        logic [1:0]  rel;
        logic [7:0]  batt;
        logic [7:0]  infl;
        logic [23:0] smp;
        int          reps;
        int          req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'b00, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h300000, 4,   2},  // R2 pass-through
        '{2'b01, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h100000, 20,  4},  // R4 attack every sample
        '{2'b01, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h010000, 40,  5},  // R5 release per 16
        '{2'b01, 1'b0, 2'b00, 5'd0,  2'b10, 2'b00, 8'd200, 8'd120, 24'hE00000, 12,  4},  // R4 negative, per 4
        '{2'b01, 1'b0, 2'b00, 5'd0,  2'b01, 2'b10, 8'd200, 8'd120, 24'h080000, 13,  6},  // R6 equal, release per 6
        '{2'b01, 1'b0, 2'b00, 5'd31, 2'b00, 2'b11, 8'd200, 8'd120, 24'h400000, 16,  6},  // R6 high threshold
        '{2'b01, 1'b1, 2'b11, 5'd31, 2'b00, 2'b11, 8'd100, 8'd120, 24'h200000, 8,   7},  // R7 slope 4 attack
        '{2'b01, 1'b1, 2'b00, 5'd31, 2'b00, 2'b01, 8'd100, 8'd120, 24'h200000, 16,  7},  // R7 slope 1 release
        '{2'b01, 1'b1, 2'b11, 5'd0,  2'b00, 2'b11, 8'd0,   8'd255, 24'h030000, 6,   7},  // R7 floor
        '{2'b10, 1'b1, 2'b00, 5'd0,  2'b00, 2'b00, 8'd100, 8'd120, 24'h100000, 4,   9},  // R9 mute
        '{2'b10, 1'b1, 2'b11, 5'd31, 2'b00, 2'b00, 8'd200, 8'd120, 24'h200000, 6,   9},  // R9 no tracking in 10
        '{2'b10, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h100000, 6,   9},  // R9 fixed limit
        '{2'b11, 1'b0, 2'b00, 5'd0,  2'b00, 2'b11, 8'd200, 8'd120, 24'h7FFFFF, 12, 10},  // R10 no attack, release
        '{2'b11, 1'b0, 2'b00, 5'd0,  2'b00, 2'b11, 8'd100, 8'd120, 24'h7FFFFF, 5,  10},  // R10 low limits
        '{2'b01, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h800000, 200, 4},  // R4 saturation
        '{2'b00, 1'b0, 2'b00, 5'd0,  2'b00, 2'b00, 8'd200, 8'd120, 24'h7FFFFF, 3,   2}   // R2 back to bypass
    };

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic upd_low();
        if (batt_code < infl_code) m_low = 1'b1;
        else if (int'(batt_code) >= int'(infl_code) + 4) m_low = 1'b0;
    endtask

    task automatic step(input logic [23:0] s, input string req);
        longint sl, pk, ts, drop, tt, thr, t;
        int aper, rper, base;
        bit mute, act, over;
        logic [23:0] eo;
        sl = longint'($signed(s));
        pk = (sl < 0) ? -sl : sl;
        ts = (longint'(thresh_sel) + 4) * 131072;
        drop = (batt_code < infl_code) ?
               (longint'(slope_sel) + 1) * (longint'(infl_code) - longint'(batt_code)) * 32768 : 0;
        tt = (ts > drop + 131072) ? ts - drop : 131072;
        thr = (track_en && (lim_mode == 2'b01 || lim_mode == 2'b11)) ? tt : ts;
        mute = (lim_mode == 2'b10) && m_low;
        act = (lim_mode == 2'b01) || (lim_mode == 2'b10 && !m_low) || (lim_mode == 2'b11 && m_low);
        over = act && (pk > thr);
        aper = 1 << attack_sel;
        case (release_sel)
            2'b00: rper = 16;
            2'b01: rper = 8;
            2'b10: rper = 6;
            default: rper = 4;
        endcase
        if (lim_mode == 2'b00) eo = s;
        else if (mute) eo = '0;
        else begin
            t = (sl * (256 - m_a)) >>> 8;
            eo = t[23:0];
        end
        if (lim_mode == 2'b00) begin m_st = 0; m_a = 0; m_cnt = 0; end
        else if (mute) begin m_st = 4; m_a = 0; m_cnt = 0; end
        else if (over) begin
            base = (m_st == 2) ? m_cnt : 0;
            m_st = 2;
            if (base + 1 >= aper) begin m_cnt = 0; if (m_a < 192) m_a++; end
            else m_cnt = base + 1;
        end else if (m_a == 0) begin m_st = 1; m_cnt = 0; end
        else begin
            base = (m_st == 3) ? m_cnt : 0;
            if (base + 1 >= rper) begin m_cnt = 0; m_a--; m_st = (m_a == 0) ? 1 : 3; end
            else begin m_cnt = base + 1; m_st = 3; end
        end
        sample_in = s;
        in_valid = 1'b1;
        @(posedge clk);
        upd_low();
        @(negedge clk);
        chk({req, " out_valid"}, out_valid, 1);         // R3
        chk({req, " sample_out"}, sample_out, eo);      // R3
        chk({req, " engaged R11"}, engaged, (m_a != 0) || (m_st == 4));
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            sample_in = 24'h7FFFFF;
            @(posedge clk);
            upd_low();
            @(negedge clk);
            chk({req, " idle out_valid R3"}, out_valid, 0);
            chk({req, " idle engaged R12"}, engaged, (m_a != 0) || (m_st == 4));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", out_valid, 0);
        chk("R1 sample_out", sample_out, 0);
        chk("R1 engaged", engaged, 0);
        rst_n = 1'b1;
        idle(1, "R1");

        for (int v = 0; v < NV; v++) begin
            lim_mode    = VECS[v].mode;
            track_en    = VECS[v].trk;
            slope_sel   = VECS[v].slope;
            thresh_sel  = VECS[v].thr;
            attack_sel  = VECS[v].att;
            release_sel = VECS[v].rel;
            batt_code   = VECS[v].batt;
            infl_code   = VECS[v].infl;
            idle(2, $sformatf("R%0d", VECS[v].req));
            for (int r = 0; r < VECS[v].reps; r++)
                step(VECS[v].smp, $sformatf("R%0d", VECS[v].req));
        end

        // R8 hysteresis: set, hold inside band, clear at inflection + 4
        lim_mode = 2'b10; track_en = 1'b0; thresh_sel = '0; infl_code = 8'd120;
        batt_code = 8'd119;
        idle(2, "R8");
        step(24'h100000, "R8 set");
        chk("R8 muted below", sample_out, 0);
        batt_code = 8'd123;
        idle(2, "R8");
        step(24'h100000, "R8 band");
        chk("R8 muted in band", sample_out, 0);
        batt_code = 8'd124;
        idle(2, "R8");
        step(24'h100000, "R8 clear");
        chk("R8 released", sample_out, 24'h100000);

        // R12 idle gaps keep the reduction
        lim_mode = 2'b01; batt_code = 8'd200;
        idle(2, "R12");
        for (int r = 0; r < 5; r++) step(24'h7FFFFF, "R12 attack");
        idle(10, "R12");
        step(24'h000100, "R12 after gap");

        // R1 reset in mid-run clears engaged and output strobe
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid engaged", engaged, 0);
        chk("R1 mid out_valid", out_valid, 0);
        chk("R1 mid sample_out", sample_out, 0);
        in_valid = 1'b0;
        m_a = 0; m_st = 1; m_cnt = 0; m_low = 1'b0;
        rst_n = 1'b1;
        idle(1, "R1");
        step(24'h100000, "R1 post");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule